// File: doc/BRIEF.md
# Dual Base Effective Address Unit

This unit computes the effective address of a memory-reference instruction when the machine runs in a mode where one control word picks two base registers from a file of eight. The low six bits of base register zero hold two 3-bit register numbers, a primary one and an alternate one. The top bit of the instruction's 16-bit address halfword chooses between them. The remaining 15 bits are an unsigned displacement.

The unit drives a combinational read index into an external eight-entry base register file and takes the returned 32-bit value back in the same cycle. It adds the zero-extended displacement to that value. If the chosen register number is zero, the base value is ignored and the displacement alone is the address.

The result is registered, so it appears one cycle after the request together with a valid strobe. The unit also checks the destination register of scratchpad instructions. In this mode only registers 0 and 1 may receive their results. A request that breaks this rule raises an illegal-instruction pulse in place of the valid strobe.

Top module: `dbase_ea_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `ea_valid` and `ea_illegal` are 0 and `ea_addr` is 0.
- R2: `breg_rd_idx` equals `base0_ctl[2:0]` (primary field) when `req_hw[15]` is 0, and `base0_ctl[5:3]` (alternate field) when `req_hw[15]` is 1, in the same cycle.
- R3: When the selected field is nonzero, `ea_addr` one cycle after an accepted request equals `breg_rd_data + req_hw[14:0]`, with the displacement zero-extended to 32 bits.
- R4: When the selected field is zero, `ea_addr` one cycle later equals `req_hw[14:0]` zero-extended, whatever `breg_rd_data` holds.
- R5: The sum of base and displacement wraps modulo 2^32, and no carry is kept.
- R6: A request with `req_valid` high and a legal destination makes `ea_valid` high for exactly the next cycle.
- R7: A request with `req_scratch` high and `req_dest` greater than 1 makes `ea_illegal` high for exactly the next cycle, and `ea_valid` stays low.
- R8: A request with `req_scratch` low is legal for every `req_dest` value 0 to 7.
- R9: In a cycle after which no request was presented, `ea_valid` and `ea_illegal` are 0 and `ea_addr` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_hw | input | 16 | Address halfword: bit 15 base select, bits 14:0 displacement |
| req_scratch | input | 1 | Request is a scratchpad instruction |
| req_dest | input | 3 | Destination register number |
| base0_ctl | input | 6 | Low six bits of base register zero: [2:0] primary, [5:3] alternate |
| breg_rd_idx | output | 3 | Read index into the base register file |
| breg_rd_data | input | 32 | Base register value returned for `breg_rd_idx` |
| ea_valid | output | 1 | Registered effective address is valid |
| ea_illegal | output | 1 | Registered illegal-destination pulse |
| ea_addr | output | 32 | Registered effective address |

## Verification
Every pair of primary and alternate fields (64 combinations) is driven with both values of the select bit. This separates a swapped field mapping from a correct one, and absolute addressing from based addressing. Each pairing is tried with a zero displacement, a mid-range displacement and the largest displacement. Each base register value is distinct, so a wrong index shows up as a wrong sum. One base value sits just below 2^32, so the largest displacement tests the wraparound. The bench then sweeps all destination numbers for scratchpad and ordinary requests, and finally runs idle cycles to confirm the strobes drop while the address holds.

// File: rtl/dbe_pkg.sv
package dbe_pkg;
  localparam int unsigned DBE_ADDR_W = 32;
  localparam int unsigned DBE_DISP_W = 15;
  localparam int unsigned DBE_IDX_W  = 3;
  localparam int unsigned DBE_DEST_W = 3;
  localparam int unsigned DBE_HW_W   = DBE_DISP_W + 1;

  typedef struct packed {
    logic                  alt_sel;
    logic [DBE_DISP_W-1:0] disp;
  } dbe_hw_t;
endpackage

// File: rtl/dbe_base_sel.sv
module dbe_base_sel #(
  parameter int unsigned IDX_W = 3
) (
  input  logic               alt_sel,
  input  logic [2*IDX_W-1:0] ctl,
  output logic [IDX_W-1:0]   rd_idx,
  output logic               absolute
);
  logic [IDX_W-1:0] pri_fld;
  logic [IDX_W-1:0] alt_fld;

  assign pri_fld = ctl[IDX_W-1:0];
  assign alt_fld = ctl[2*IDX_W-1:IDX_W];

  always_comb begin
    rd_idx   = alt_sel ? alt_fld : pri_fld;
    absolute = (rd_idx == '0);
  end
endmodule

// File: rtl/dbe_addr_gen.sv
module dbe_addr_gen #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 15
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DISP_W-1:0] disp,
  input  logic              absolute,
  output logic [ADDR_W-1:0] ea
);
  localparam int unsigned PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] base_eff;

  assign disp_ext = {{PAD_W{1'b0}}, disp};

  always_comb begin
    base_eff = absolute ? '0 : base;
    ea       = base_eff + disp_ext;
  end
endmodule

// File: rtl/dbe_dest_chk.sv
module dbe_dest_chk #(
  parameter int unsigned DEST_W   = 3,
  parameter int unsigned MAX_DEST = 1
) (
  input  logic              is_scratch,
  input  logic [DEST_W-1:0] dest,
  output logic              legal
);
  localparam logic [DEST_W-1:0] LIMIT = DEST_W'(MAX_DEST);

  always_comb begin
    legal = !is_scratch || (dest <= LIMIT);
  end
endmodule

// File: rtl/dbase_ea_unit.sv
module dbase_ea_unit
  import dbe_pkg::*;
#(
  parameter int unsigned ADDR_W       = DBE_ADDR_W,
  parameter int unsigned DISP_W       = DBE_DISP_W,
  parameter int unsigned IDX_W        = DBE_IDX_W,
  parameter int unsigned DEST_W       = DBE_DEST_W,
  parameter int unsigned SCR_MAX_DEST = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [DISP_W:0]     req_hw,
  input  logic                req_scratch,
  input  logic [DEST_W-1:0]   req_dest,
  input  logic [2*IDX_W-1:0]  base0_ctl,
  output logic [IDX_W-1:0]    breg_rd_idx,
  input  logic [ADDR_W-1:0]   breg_rd_data,
  output logic                ea_valid,
  output logic                ea_illegal,
  output logic [ADDR_W-1:0]   ea_addr
);
  logic              alt_sel;
  logic [DISP_W-1:0] disp;
  logic              absolute;
  logic              legal;
  logic [ADDR_W-1:0] ea_next;

  assign alt_sel = req_hw[DISP_W];
  assign disp    = req_hw[DISP_W-1:0];

  dbe_base_sel #(.IDX_W(IDX_W)) u_sel (
    .alt_sel  (alt_sel),
    .ctl      (base0_ctl),
    .rd_idx   (breg_rd_idx),
    .absolute (absolute)
  );

  dbe_addr_gen #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_gen (
    .base     (breg_rd_data),
    .disp     (disp),
    .absolute (absolute),
    .ea       (ea_next)
  );

  dbe_dest_chk #(.DEST_W(DEST_W), .MAX_DEST(SCR_MAX_DEST)) u_chk (
    .is_scratch (req_scratch),
    .dest       (req_dest),
    .legal      (legal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid   <= 1'b0;
      ea_illegal <= 1'b0;
      ea_addr    <= '0;
    end else begin
      ea_valid   <= req_valid && legal;
      ea_illegal <= req_valid && !legal;
      if (req_valid && legal) begin
        ea_addr <= ea_next;
      end
    end
  end
endmodule

// File: rtl/dbase_ea_unit_checker.sv
module dbase_ea_unit_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DISP_W = 15,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned DEST_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [DISP_W:0]    req_hw,
  input logic               req_scratch,
  input logic [DEST_W-1:0]  req_dest,
  input logic [2*IDX_W-1:0] base0_ctl,
  input logic [IDX_W-1:0]   breg_rd_idx,
  input logic               ea_valid,
  input logic               ea_illegal,
  input logic [ADDR_W-1:0]  ea_addr
);
  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ea_valid && ea_illegal));

  // R6
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ea_valid |-> $past(req_valid));

  // R7
  illegal_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ea_illegal |-> $past(req_valid && req_scratch && (req_dest > DEST_W'(1))));

  // R8
  plain_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_scratch) |=> ea_valid);

  // R4
  absolute_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (breg_rd_idx == '0) && (!req_scratch || req_dest <= DEST_W'(1)))
      |=> (ea_addr == {{(ADDR_W-DISP_W){1'b0}}, $past(req_hw[DISP_W-1:0])}));

  // R9
  hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!ea_valid && !ea_illegal && $stable(ea_addr)));
endmodule

bind dbase_ea_unit dbase_ea_unit_checker #(
  .ADDR_W(ADDR_W), .DISP_W(DISP_W), .IDX_W(IDX_W), .DEST_W(DEST_W)
) u_dbase_ea_unit_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_hw     (req_hw),
  .req_scratch(req_scratch),
  .req_dest   (req_dest),
  .base0_ctl  (base0_ctl),
  .breg_rd_idx(breg_rd_idx),
  .ea_valid   (ea_valid),
  .ea_illegal (ea_illegal),
  .ea_addr    (ea_addr)
);

// File: tb/dbase_ea_unit_bench.sv
`timescale 1ns/1ps
module dbase_ea_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_hw = '0;
  logic        req_scratch = 1'b0;
  logic [2:0]  req_dest = '0;
  logic [5:0]  base0_ctl = '0;
  logic [2:0]  breg_rd_idx;
  logic [31:0] breg_rd_data;
  logic        ea_valid;
  logic        ea_illegal;
  logic [31:0] ea_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [31:0] base_val(input logic [2:0] i);
    if (i == 3'd7) return 32'hFFFF_FF00;
    return 32'h0101_0101 * {29'd0, i} + 32'h0000_0010;
  endfunction

  assign breg_rd_data = base_val(breg_rd_idx);

  dbase_ea_unit u_dbase_ea_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_hw(req_hw),
    .req_scratch(req_scratch), .req_dest(req_dest), .base0_ctl(base0_ctl),
    .breg_rd_idx(breg_rd_idx), .breg_rd_data(breg_rd_data),
    .ea_valid(ea_valid), .ea_illegal(ea_illegal), .ea_addr(ea_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] ctl, input logic sel, input logic [14:0] d,
                       input logic scr, input logic [2:0] dst);
    logic [2:0]  fld;
    logic [31:0] exp_a;
    logic        leg;
    @(negedge clk);
    base0_ctl   = ctl;
    req_hw      = {sel, d};
    req_scratch = scr;
    req_dest    = dst;
    req_valid   = 1'b1;
    fld   = sel ? ctl[5:3] : ctl[2:0];
    exp_a = (fld == 3'd0) ? {17'd0, d} : base_val(fld) + {17'd0, d};
    leg   = !scr || (dst <= 3'd1);
    #0.5;
    chk("R2 read index", {29'd0, breg_rd_idx}, {29'd0, fld});
    @(negedge clk);
    req_valid = 1'b0;
    if (leg) begin
      chk("R6 valid", {31'd0, ea_valid}, 32'd1);
      if (fld == 3'd0) chk("R4 absolute addr", ea_addr, exp_a);
      else if (fld == 3'd7 && d == 15'h7FFF) chk("R5 wrap addr", ea_addr, exp_a);
      else chk("R3 based addr", ea_addr, exp_a);
      chk(scr ? "R6 no illegal" : "R8 plain legal", {31'd0, ea_illegal}, 32'd0);
    end else begin
      chk("R7 illegal pulse", {31'd0, ea_illegal}, 32'd1);
      chk("R7 valid low", {31'd0, ea_valid}, 32'd0);
    end
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, ea_valid}, 32'd0);
    chk("R1 reset illegal", {31'd0, ea_illegal}, 32'd0);
    chk("R1 reset addr", ea_addr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 post-reset valid", {31'd0, ea_valid}, 32'd0);
    chk("R1 post-reset addr", ea_addr, 32'd0);

    for (int c = 0; c < 64; c++) begin
      for (int s = 0; s < 2; s++) begin
        issue(6'(c), 1'(s), 15'h0000, 1'b0, 3'd0);
        issue(6'(c), 1'(s), 15'h1234, 1'b1, 3'd1);
        issue(6'(c), 1'(s), 15'h7FFF, 1'b0, 3'd5);
      end
    end

    for (int sc = 0; sc < 2; sc++) begin
      for (int dd = 0; dd < 8; dd++) begin
        issue(6'o35, 1'b0, 15'h0042, 1'(sc), 3'(dd));
      end
    end

    issue(6'o21, 1'b1, 15'h0ABC, 1'b0, 3'd2);
    held = ea_addr;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R9 idle valid", {31'd0, ea_valid}, 32'd0);
      chk("R9 idle illegal", {31'd0, ea_illegal}, 32'd0);
      chk("R9 idle addr hold", ea_addr, held);
    end

    issue(6'o21, 1'b0, 15'h0001, 1'b1, 3'd6);
    chk("R7 addr hold after illegal", ea_addr, held);

    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule